// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block adds byte transfers to a single-wire bus master. Software writes a byte to the data register. The byte waits in a transmit buffer and then moves into a shift register. The engine runs eight bit slots through an external slot-timing unit, sending the least-significant bit first. Each slot returns one sampled line level. The eight samples form a received byte, which is placed in a receive buffer. To read a byte from a device, software writes 0xFF. Every slot is then a write-1 slot that lets the device pull the line low, so the sampled bits are the device's byte.

A status register carries four flags:

- transmit buffer empty
- shift register idle
- receive buffer full
- received byte held in the shift register

A mask register selects which flags drive the single interrupt line. Suppose a byte completes while the receive buffer is still unread. The byte then stays in the shift register, and no new slots start until software reads the data register. Nothing is ever overwritten.

The slot interface is a valid/ready request. The engine raises `slot_valid` with the bit to send and holds both until `slot_ready` is seen high on a clock edge. The slot unit may hold `slot_ready` low for as long as it needs. The engine then waits for a one-cycle `slot_done` pulse that carries `slot_sample`. It issues no further request until that pulse arrives.

Top module: `onewire_byte_engine`

## Requirements
- R1: After reset, the status register reads 0x0C, the mask register reads 0, the data register reads 0 and `irq` is low.
- R2: A write to the data register (address 0) while the transmit buffer is empty is accepted, and the transmit-empty flag reads 0 on the next cycle. The byte is then sent as eight slots, bit 0 first, and each slot's `slot_bit` equals the corresponding byte bit.
- R3: A write to the data register while the transmit buffer is full is ignored. That value is never sent.
- R4: `slot_valid` stays high and `slot_bit` stays stable until `slot_ready` is sampled high. Exactly one request is made per slot, and each request waits for its `slot_done` pulse.
- R5: The sample of the k-th slot of a byte (k counted from 0) becomes bit k of the received byte. Writing 0xFF therefore returns the device's byte, and writing any other value returns that value ANDed with the line.
- R6: When a byte completes and the receive buffer is empty, the byte enters the receive buffer and the receive-full flag sets. The shift-idle flag sets once no byte is queued. A byte queued in the transmit buffer starts without software help.
- R7: A read of the data register returns the receive buffer and clears the receive-full flag.
- R8: A byte that completes while the receive buffer is full sets the shift-held flag. No new slots start while that flag is set. The held byte moves into the receive buffer after the data register is read, and the held flag then clears.
- R9: Status register (address 1) bit positions: bit 2 is transmit buffer empty, bit 3 is shift register idle, bit 4 is receive buffer full, and bit 5 is received byte held. All other bits read 0, and address 3 reads 0.
- R10: The mask register (address 2) stores bits 2 to 5 and reads back 0 in all other bits. `irq` is high exactly when some status flag is set and its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read clears the receive-full flag) |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| slot_valid | output | 1 | Slot request valid |
| slot_ready | input | 1 | Slot unit accepts the request |
| slot_bit | output | 1 | Bit to send in the requested slot |
| slot_done | input | 1 | One-cycle pulse at the end of a slot |
| slot_sample | input | 1 | Line level sampled in the finished slot |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The hardest state to reach is the receive overflow. Two whole bytes must complete with no read in between, and a third byte must then sit in the transmit buffer. Only then can the bench observe the stall and see the held byte handed over after a read. The bench queues a second byte as soon as the first has moved into the shift register. It waits for the held flag and then writes a third byte. It confirms through the status register and its own slot log that nothing moves until the data register is read. Back-pressure on the slot request is produced by a slot model that delays `slot_ready` by a programmable number of cycles.

// File: rtl/ow_byte_pkg.sv
package ow_byte_pkg;
  localparam int unsigned FLG_TX_EMPTY  = 2;
  localparam int unsigned FLG_SH_IDLE   = 3;
  localparam int unsigned FLG_RX_FULL   = 4;
  localparam int unsigned FLG_RX_HELD   = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_FLAGS = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ow_tx_path.sv
module ow_tx_path
  import ow_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_hold,
  input  logic              slot_ready,
  input  logic              slot_done,
  output logic              slot_valid,
  output logic              slot_bit,
  output logic              tx_empty,
  output logic              shift_idle,
  output logic              bit_done,
  output logic              byte_done
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  seq_state_e        state_q;
  logic [DATA_W-1:0] txbuf_q;
  logic              txfull_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  assign slot_valid = (state_q == SEQ_REQ);
  assign slot_bit   = shreg_q[0];
  assign tx_empty   = !txfull_q;
  assign shift_idle = (state_q == SEQ_IDLE);
  assign bit_done   = (state_q == SEQ_WAIT) && slot_done;
  assign byte_done  = bit_done && (cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      txbuf_q  <= '0;
      txfull_q <= 1'b0;
      shreg_q  <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_data_en && !txfull_q) begin
        txbuf_q  <= wr_data;
        txfull_q <= 1'b1;
      end
      unique case (state_q)
        SEQ_IDLE: begin
          if (txfull_q && !rx_hold) begin
            shreg_q  <= txbuf_q;
            txfull_q <= 1'b0;
            cnt_q    <= '0;
            state_q  <= SEQ_REQ;
          end
        end
        SEQ_REQ: begin
          if (slot_ready) state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (slot_done) begin
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
            state_q <= (cnt_q == LAST_BIT) ? SEQ_IDLE : SEQ_REQ;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_bit)));

  // R4
  one_req_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && slot_ready) |=> !slot_valid);

  // R3
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_en && txfull_q) |=> $stable(txbuf_q));

  // R2
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_en && !txfull_q) |=> !tx_empty);

  // R8
  stall_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold && shift_idle) |=> shift_idle);
endmodule

// File: rtl/ow_rx_path.sv
module ow_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              byte_done,
  input  logic              sample,
  input  logic              rd_data_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_hold
);
  logic [DATA_W-1:0] rxsh_q;
  logic [DATA_W-1:0] rxbuf_q;
  logic [DATA_W-1:0] rxsh_next;
  logic              full_q;
  logic              hold_q;

  if (DATA_W > 1) begin : g_wide
    assign rxsh_next = {sample, rxsh_q[DATA_W-1:1]};
  end else begin : g_narrow
    assign rxsh_next = sample;
  end

  assign rx_data = rxbuf_q;
  assign rx_full = full_q;
  assign rx_hold = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxsh_q  <= '0;
      rxbuf_q <= '0;
      full_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (bit_done) rxsh_q <= rxsh_next;
      if (rd_data_en) full_q <= 1'b0;
      if (byte_done) begin
        if (!full_q) begin
          rxbuf_q <= rxsh_next;
          full_q  <= 1'b1;
        end else begin
          hold_q <= 1'b1;
        end
      end else if (hold_q && !full_q) begin
        rxbuf_q <= rxsh_q;
        full_q  <= 1'b1;
        hold_q  <= 1'b0;
      end
    end
  end

  // R6
  fill_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !full_q) |=> rx_full);

  // R8
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full_q) |=> rx_hold);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && !byte_done && !hold_q) |=> !rx_full);

  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && full_q) |=> $stable(rxsh_q));
endmodule

// File: rtl/ow_reg_file.sv
module ow_reg_file
  import ow_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_empty,
  input  logic              shift_idle,
  input  logic              rx_full,
  input  logic              rx_hold,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              wr_data_en,
  output logic              rd_data_en
);
  localparam logic [DATA_W-1:0] FLAG_BITS =
    DATA_W'((1 << FLG_TX_EMPTY) | (1 << FLG_SH_IDLE) |
            (1 << FLG_RX_FULL) | (1 << FLG_RX_HELD));

  reg_sel_e          sel;
  logic [DATA_W-1:0] flags;
  logic [DATA_W-1:0] mask_q;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    flags = '0;
    flags[FLG_TX_EMPTY] = tx_empty;
    flags[FLG_SH_IDLE]  = shift_idle;
    flags[FLG_RX_FULL]  = rx_full;
    flags[FLG_RX_HELD]  = rx_hold;
  end

  assign wr_data_en = reg_wr && (sel == SEL_DATA);
  assign rd_data_en = reg_rd && (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr && (sel == SEL_MASK)) mask_q <= reg_wdata & FLAG_BITS;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA:  reg_rdata = rx_data;
      SEL_FLAGS: reg_rdata = flags;
      SEL_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(flags & mask_q);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R9
  flag_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_FLAGS) |-> ((reg_rdata & ~FLAG_BITS) == '0));
endmodule

// File: rtl/onewire_byte_engine.sv
module onewire_byte_engine #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              slot_valid,
  input  logic              slot_ready,
  output logic              slot_bit,
  input  logic              slot_done,
  input  logic              slot_sample,
  output logic              irq
);
  logic              wr_data_en;
  logic              rd_data_en;
  logic              tx_empty;
  logic              shift_idle;
  logic              bit_done;
  logic              byte_done;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full;
  logic              rx_hold;

  ow_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_data    (reg_wdata),
    .rx_hold    (rx_hold),
    .slot_ready (slot_ready),
    .slot_done  (slot_done),
    .slot_valid (slot_valid),
    .slot_bit   (slot_bit),
    .tx_empty   (tx_empty),
    .shift_idle (shift_idle),
    .bit_done   (bit_done),
    .byte_done  (byte_done)
  );

  ow_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_done   (bit_done),
    .byte_done  (byte_done),
    .sample     (slot_sample),
    .rd_data_en (rd_data_en),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_hold    (rx_hold)
  );

  ow_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rx_data    (rx_data),
    .tx_empty   (tx_empty),
    .shift_idle (shift_idle),
    .rx_full    (rx_full),
    .rx_hold    (rx_hold),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .wr_data_en (wr_data_en),
    .rd_data_en (rd_data_en)
  );
endmodule

// File: tb/onewire_byte_engine_test.sv
module onewire_byte_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       slot_valid;
  logic       slot_ready = 1'b0;
  logic       slot_bit;
  logic       slot_done = 1'b0;
  logic       slot_sample = 1'b0;
  logic       irq;

  int errors = 0;
  int checks = 0;

  // slot model state
  logic [7:0] dev_byte = 8'hFF;
  int         ready_lag = 0;
  logic [7:0] sent [0:7];
  int         sent_cnt = 0;
  int         bidx = 0;
  logic [7:0] acc = 8'd0;

  always #2.5 clk = ~clk;

  onewire_byte_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_bit(slot_bit),
    .slot_done(slot_done), .slot_sample(slot_sample), .irq(irq)
  );

  // Slot timing model: wired-AND line, latency of 3 cycles after acceptance
  initial begin
    int phase = 0;
    int lat = 0;
    int lag = 0;
    logic wbit = 1'b0;
    forever begin
      @(negedge clk);
      slot_done = 1'b0;
      if (phase == 1) begin
        slot_ready = 1'b0;
        phase = 2;
        lat = 3;
      end else if (phase == 2) begin
        lat = lat - 1;
        if (lat == 0) begin
          slot_done = 1'b1;
          slot_sample = wbit & dev_byte[bidx];
          acc[bidx] = wbit;
          bidx = bidx + 1;
          if (bidx == 8) begin
            if (sent_cnt < 8) sent[sent_cnt] = acc;
            sent_cnt = sent_cnt + 1;
            bidx = 0;
          end
          phase = 0;
        end
      end else if (slot_valid) begin
        if (lag < ready_lag) lag = lag + 1;
        else begin
          slot_ready = 1'b1;
          wbit = slot_bit;
          phase = 1;
          lag = 0;
        end
      end
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_flag(int pos, logic val);
    logic [7:0] f;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd1, f);
      if (f[pos] == val) return;
    end
    check("wait_flag", 0, 1);
  endtask

  task automatic clear_log();
    sent_cnt = 0;
    bidx = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(2'd1, d); check("R1 flags", d, 8'h0C);
    check("R9 flag bits", d & 8'hC3, 0);
    reg_read(2'd2, d); check("R1 mask", d, 0);
    reg_read(2'd0, d); check("R1 data", d, 0);
    reg_read(2'd3, d); check("R9 unused addr", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_write_byte();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd0, 8'hA5);
    reg_read(2'd1, d); check("R2 tx empty cleared", d[2], 0);
    wait_flag(4, 1'b1);
    check("R2 byte sent", sent[0], 8'hA5);
    reg_read(2'd0, d); check("R5 echo", d, 8'hA5);
    reg_read(2'd1, d); check("R7 rx full cleared", d, 8'h0C);
  endtask

  task automatic t_read_byte(logic [7:0] dev);
    logic [7:0] d;
    clear_log(); dev_byte = dev;
    reg_write(2'd0, 8'hFF);
    wait_flag(4, 1'b1);
    check("R5 write-1 slots", sent[0], 8'hFF);
    reg_read(2'd0, d); check("R5 received", d, dev);
  endtask

  task automatic t_wired_and();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hF0;
    reg_write(2'd0, 8'h3C);
    wait_flag(4, 1'b1);
    reg_read(2'd0, d); check("R5 and with line", d, 8'h30);
  endtask

  task automatic t_queue_and_drop();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd0, 8'h12);
    wait_flag(2, 1'b1);
    reg_write(2'd0, 8'h34);
    reg_write(2'd0, 8'h56);
    wait_flag(4, 1'b1);
    reg_read(2'd0, d); check("R6 first byte", d, 8'h12);
    wait_flag(4, 1'b1);
    reg_read(2'd0, d); check("R6 queued byte", d, 8'h34);
    repeat (200) @(negedge clk);
    check("R3 byte count", sent_cnt, 2);
    check("R3 second sent", sent[1], 8'h34);
    reg_read(2'd1, d); check("R6 idle flags", d, 8'h0C);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd0, 8'h11);
    wait_flag(2, 1'b1);
    reg_write(2'd0, 8'h22);
    wait_flag(5, 1'b1);
    reg_write(2'd0, 8'h33);
    repeat (100) @(negedge clk);
    reg_read(2'd1, d); check("R8 stalled flags", d, 8'h38);
    check("R8 no slots while held", sent_cnt, 2);
    reg_read(2'd0, d); check("R8 first", d, 8'h11);
    wait_flag(4, 1'b1);
    reg_read(2'd1, d); check("R8 held cleared", d[5], 0);
    reg_read(2'd0, d); check("R8 held byte", d, 8'h22);
    wait_flag(4, 1'b1);
    reg_read(2'd0, d); check("R8 resumed byte", d, 8'h33);
    check("R8 total", sent_cnt, 3);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hFF;
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, d); check("R10 mask readback", d, 8'h3C);
    check("R10 irq idle flags", irq, 1);
    reg_write(2'd2, 8'h10);
    check("R10 irq masked", irq, 0);
    reg_write(2'd0, 8'h77);
    wait_flag(4, 1'b1);
    check("R10 irq rx full", irq, 1);
    reg_read(2'd0, d);
    check("R10 irq after read", irq, 0);
    reg_write(2'd2, 8'h00);
    check("R10 irq mask zero", irq, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    clear_log(); dev_byte = 8'hFF; ready_lag = 6;
    reg_write(2'd0, 8'h5A);
    wait_flag(4, 1'b1);
    check("R4 sent under stall", sent[0], 8'h5A);
    reg_read(2'd0, d); check("R4 received under stall", d, 8'h5A);
    ready_lag = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_byte();
    t_read_byte(8'h3C);
    t_read_byte(8'h81);
    t_wired_and();
    t_queue_and_drop();
    t_overflow();
    t_irq();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule